// File: doc/BRIEF.md
# Match-Compare OS Timer

This block is a memory-mapped system timer built around one free-running up-counter and a small set of 32-bit compare channels. The counter advances by one on every cycle in which the `tick` strobe is high. The strobe is expected to come from a divider running off a fixed base clock. Software can load the counter at any time, and counting then carries on from the loaded value. The counter has no terminal count and rolls over to zero after its all-ones value.

Each channel compares its match value against the value the counter is about to take on a tick. If that channel's interrupt enable is set, a hit latches a sticky status bit, and the channel's interrupt line then stays high until software clears the bit by writing a one to it. The last channel also serves as a one-shot watchdog. When the watchdog is armed, a hit on that channel raises a single-cycle reset request and disarms the watchdog in the same step.

A word-wide register port gives access to every register. Reads are combinational and single-cycle, and writes take effect on the next clock edge. An access to an offset that holds no register is flagged on a one-cycle error output.

Top module: `os_match_timer`

## Requirements
- R1: After reset the counter, all match values, the status bits, the interrupt enables and the watchdog register read as zero, and `irq`, `wdt_reset_req` and `bus_err` are low.
- R2: Each cycle with `tick` high and no counter write adds one to the counter, and the counter rolls from 0xFFFFFFFF to 0. With `tick` low and no counter write, the counter holds.
- R3: A write to the counter loads the written value at the next edge, even when `tick` is high in that cycle, and later ticks count up from the loaded value.
- R4: On a tick that makes the counter equal to match value N while enable bit N is set, status bit N (bit position N of the status register) is set at that edge, and `irq[N]` is high from the next cycle.
- R5: A hit on channel N while enable bit N is clear sets no status bit and raises no interrupt.
- R6: A status write clears each status bit whose data bit is one and leaves the bits written as zero unchanged. If a hit and a clear reach the same bit in the same cycle, the bit ends up set.
- R7: The interrupt-enable register holds only data bits 11:0, and bits 31:12 always read as zero.
- R8: `irq[N]` is a level equal to status bit N AND enable bit N. Clearing the enable drops the line but keeps the status bit.
- R9: A hit on the last channel (channel 3) while bit 0 of the watchdog register is set drives `wdt_reset_req` high for exactly one cycle and clears the watchdog register to zero. This does not depend on that channel's interrupt enable.
- R10: A read of an unmapped or misaligned offset returns zero. A write to such an offset changes no register. In both cases `bus_err` is high for exactly the one cycle after the access.
- R11: The byte offsets are: match N at 4*N (0x00 to 0x0C), counter at 0x10, status at 0x14, watchdog at 0x18 and interrupt enable at 0x1C. The match and watchdog registers read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-enable strobe from the base clock divider |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when no read is active |
| irq | output | 4 | Per-channel interrupt levels |
| wdt_reset_req | output | 1 | One-cycle system reset request from the watchdog channel |
| bus_err | output | 1 | One-cycle flag after an access to an unmapped offset |

## Verification
The bench targets the rollover from all ones to zero. A counter that compared its current value instead of its next value would report matches one tick late, and a counter that saturated would stall at the top. It also checks a counter load issued in the same cycle as a tick: if the tick won, the loaded value would read back off by one. It drives a hit and a status clear into the same bit in one cycle, which a clear-priority design would lose. It lets the watchdog channel hit twice, and a design that failed to disarm would reset twice. Finally, it writes to unmapped and misaligned offsets next to real registers, where a loose decoder would corrupt a match value.

// File: rtl/os_match_timer_pkg.sv
package os_match_timer_pkg;

   // byte offsets of the register file
   localparam int unsigned OFS_MATCH_BASE = 'h00;
   localparam int unsigned REG_STRIDE     = 4;
   localparam int unsigned OFS_COUNT      = 'h10;
   localparam int unsigned OFS_STATUS     = 'h14;
   localparam int unsigned OFS_WDOG       = 'h18;
   localparam int unsigned OFS_IRQ_EN     = 'h1C;
   localparam int unsigned MAX_CHANNELS   = 4;

   typedef struct packed {
      logic count;
      logic status;
      logic wdog;
      logic irq_en;
      logic mapped;
   } reg_sel_t;

endpackage

// File: rtl/os_tmr_decode.sv
module os_tmr_decode
   import os_match_timer_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int N_CH   = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_CH-1:0]   sel_match,
   output reg_sel_t          sel
);

   for (genvar n = 0; n < N_CH; n++) begin : g_match_sel
      assign sel_match[n] = (addr == ADDR_W'(OFS_MATCH_BASE + n * REG_STRIDE));
   end

   always_comb begin
      sel.count  = (addr == ADDR_W'(OFS_COUNT));
      sel.status = (addr == ADDR_W'(OFS_STATUS));
      sel.wdog   = (addr == ADDR_W'(OFS_WDOG));
      sel.irq_en = (addr == ADDR_W'(OFS_IRQ_EN));
      sel.mapped = (|sel_match) | sel.count | sel.status | sel.wdog | sel.irq_en;
   end

endmodule

// File: rtl/os_tmr_counter.sv
module os_tmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             adv,
   output logic [CNT_W-1:0] inc_val
);

   // a load always takes priority over a tick in the same cycle
   assign adv     = tick & ~load;
   assign inc_val = cnt_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (adv) begin
         cnt_q <= inc_val;
      end
   end

endmodule

// File: rtl/os_tmr_chan.sv
module os_tmr_chan #(
   parameter int CNT_W    = 32,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_match,
   input  logic [CNT_W-1:0] wdata,
   input  logic             adv,
   input  logic [CNT_W-1:0] inc_val,
   input  logic             en,
   input  logic             clr,
   output logic [CNT_W-1:0] match_q,
   output logic             stat_q,
   output logic             hit
);

   logic set;
   logic stat_d;

   // compare against the value the counter takes at this edge
   assign hit = adv & (inc_val == match_q);
   assign set = hit & en;

   if (SET_WINS) begin : g_set_prio
      assign stat_d = set | (stat_q & ~clr);
   end else begin : g_clr_prio
      assign stat_d = (set | stat_q) & ~clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= '0;
         stat_q  <= 1'b0;
      end else begin
         stat_q <= stat_d;
         if (wr_match) begin
            match_q <= wdata;
         end
      end
   end

endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
   import os_match_timer_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 32,
   parameter int ADDR_W   = 8,
   parameter int N_CH     = 4,
   parameter int IEN_W    = 12,
   parameter int WDT_CH   = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [N_CH-1:0]   irq,
   output logic              wdt_reset_req,
   output logic              bus_err
);

   // elaboration-time parameter checks
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt_w
      $error("os_match_timer: CNT_W must lie in 2..DATA_W");
   end
   if (N_CH < 1 || N_CH > int'(MAX_CHANNELS)) begin : g_bad_n_ch
      $error("os_match_timer: N_CH must lie in 1..4");
   end
   if (WDT_CH < 0 || WDT_CH >= N_CH) begin : g_bad_wdt_ch
      $error("os_match_timer: WDT_CH must name an existing channel");
   end
   if (IEN_W < N_CH || IEN_W > DATA_W) begin : g_bad_ien_w
      $error("os_match_timer: IEN_W must lie in N_CH..DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("os_match_timer: ADDR_W too narrow for the register map");
   end

   logic [N_CH-1:0]  sel_match;
   reg_sel_t         sel;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] inc_val;
   logic             adv;
   logic [CNT_W-1:0] match_q [N_CH];
   logic [N_CH-1:0]  stat_q;
   logic [N_CH-1:0]  hit;
   logic [N_CH-1:0]  clr;
   logic [IEN_W-1:0] ien_q;
   logic [DATA_W-1:0] wdt_q;
   logic             wdt_fire;

   os_tmr_decode #(
      .ADDR_W (ADDR_W),
      .N_CH   (N_CH)
   ) u_decode (
      .addr      (addr),
      .sel_match (sel_match),
      .sel       (sel)
   );

   os_tmr_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (wr_en & sel.count),
      .load_val (wdata[CNT_W-1:0]),
      .cnt_q    (cnt_q),
      .adv      (adv),
      .inc_val  (inc_val)
   );

   // write-one-to-clear, masked by the bits currently set
   assign clr = (wr_en & sel.status) ? (wdata[N_CH-1:0] & stat_q) : '0;

   for (genvar n = 0; n < N_CH; n++) begin : g_chan
      os_tmr_chan #(
         .CNT_W    (CNT_W),
         .SET_WINS (SET_WINS)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_match (wr_en & sel_match[n]),
         .wdata    (wdata[CNT_W-1:0]),
         .adv      (adv),
         .inc_val  (inc_val),
         .en       (ien_q[n]),
         .clr      (clr[n]),
         .match_q  (match_q[n]),
         .stat_q   (stat_q[n]),
         .hit      (hit[n])
      );
   end

   assign wdt_fire = hit[WDT_CH] & wdt_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q         <= '0;
         wdt_q         <= '0;
         wdt_reset_req <= 1'b0;
         bus_err       <= 1'b0;
      end else begin
         bus_err       <= (rd_en | wr_en) & ~sel.mapped;
         wdt_reset_req <= wdt_fire;
         if (wr_en && sel.irq_en) begin
            ien_q <= wdata[IEN_W-1:0];
         end
         // a firing watchdog disarms itself ahead of any software write
         if (wdt_fire) begin
            wdt_q <= '0;
         end else if (wr_en && sel.wdog) begin
            wdt_q <= wdata;
         end
      end
   end

   assign irq = stat_q & ien_q[N_CH-1:0];

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         for (int n = 0; n < N_CH; n++) begin
            if (sel_match[n]) begin
               rdata = DATA_W'(match_q[n]);
            end
         end
         if (sel.count)  rdata = DATA_W'(cnt_q);
         if (sel.status) rdata = DATA_W'(stat_q);
         if (sel.wdog)   rdata = wdt_q;
         if (sel.irq_en) rdata = DATA_W'(ien_q);
      end
   end

endmodule

// File: rtl/os_match_timer_chk.sv
module os_match_timer_chk
   import os_match_timer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8,
   parameter int N_CH   = 4,
   parameter int IEN_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [N_CH-1:0]   irq,
   input logic              wdt_reset_req,
   input logic              bus_err,
   input logic [CNT_W-1:0]  cnt,
   input logic [N_CH-1:0]   stat,
   input logic [IEN_W-1:0]  ien,
   input logic [DATA_W-1:0] wdt_en
);

   logic ld;
   logic known;

   assign ld = wr_en && (addr == ADDR_W'(OFS_COUNT));
   // independent view of the map: aligned, and either a match slot or 0x10..0x1C
   assign known = (addr[1:0] == 2'b00) &&
                  ((addr < ADDR_W'(N_CH * 4)) ||
                   ((addr >= ADDR_W'('h10)) && (addr <= ADDR_W'('h1C))));

   assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ld) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld) |=> $stable(cnt));

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> cnt == $past(wdata[CNT_W-1:0]));

   assert_no_stat_without_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat & ~$past(stat) & ~$past(ien[N_CH-1:0])) == '0);

   assert_ien_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(OFS_IRQ_EN)) |-> (rdata >> IEN_W) == '0);

   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~ien[N_CH-1:0]) | (irq & ~stat)) == '0);

   assert_wdt_disarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset_req |-> wdt_en == '0);

   assert_wdt_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_reset_req |=> !wdt_reset_req);

   assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(rd_en || wr_en));

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !known) |-> rdata == '0);

endmodule

bind os_match_timer os_match_timer_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W),
   .N_CH   (N_CH),
   .IEN_W  (IEN_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tick          (tick),
   .wr_en         (wr_en),
   .rd_en         (rd_en),
   .addr          (addr),
   .wdata         (wdata),
   .rdata         (rdata),
   .irq           (irq),
   .wdt_reset_req (wdt_reset_req),
   .bus_err       (bus_err),
   .cnt           (cnt_q),
   .stat          (stat_q),
   .ien           (ien_q),
   .wdt_en        (wdt_q)
);

// File: tb/os_match_timer_tb.sv
module os_match_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;
   logic        wdt_reset_req;
   logic        bus_err;

   int total = 0;
   int bad = 0;
   int wdt_pulses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   os_match_timer u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .wr_en         (wr_en),
      .rd_en         (rd_en),
      .addr          (addr),
      .wdata         (wdata),
      .rdata         (rdata),
      .irq           (irq),
      .wdt_reset_req (wdt_reset_req),
      .bus_err       (bus_err)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_match [4];
   logic [31:0] m_cnt;
   logic [31:0] m_wdt;
   logic [3:0]  m_stat;
   logic [11:0] m_ien;
   logic        e_wdt;
   logic        e_err;

   function automatic bit m_known(logic [7:0] a);
      return (a == 8'h00) || (a == 8'h04) || (a == 8'h08) || (a == 8'h0C) ||
             (a == 8'h10) || (a == 8'h14) || (a == 8'h18) || (a == 8'h1C);
   endfunction

   always @(posedge clk) begin : model
      logic [31:0] nc;
      logic [3:0]  hits;
      logic [3:0]  ns;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) m_match[i] = 0;
         m_cnt = 0; m_wdt = 0; m_stat = 0; m_ien = 0; e_wdt = 0; e_err = 0;
      end else begin
         hits = 0;
         if (wr_en && addr == 8'h10) begin
            nc = wdata;
         end else if (tick) begin
            nc = m_cnt + 1;
            for (int i = 0; i < 4; i++) if (nc == m_match[i]) hits[i] = 1'b1;
         end else begin
            nc = m_cnt;
         end
         ns = m_stat;
         if (wr_en && addr == 8'h14) ns = ns & ~wdata[3:0];
         ns = ns | (hits & m_ien[3:0]);
         e_wdt = hits[3] && m_wdt[0];
         if (e_wdt) m_wdt = 0;
         else if (wr_en && addr == 8'h18) m_wdt = wdata;
         if (wr_en && addr == 8'h1C) m_ien = wdata[11:0];
         for (int i = 0; i < 4; i++)
            if (wr_en && addr == 8'(4 * i)) m_match[i] = wdata;
         e_err = (rd_en || wr_en) && !m_known(addr);
         m_cnt = nc;
         m_stat = ns;
      end
   end

   function automatic logic [31:0] m_read(logic [7:0] a);
      case (a)
         8'h00: return m_match[0];
         8'h04: return m_match[1];
         8'h08: return m_match[2];
         8'h0C: return m_match[3];
         8'h10: return m_cnt;
         8'h14: return {28'd0, m_stat};
         8'h18: return m_wdt;
         8'h1C: return {20'd0, m_ien};
         default: return 32'd0;
      endcase
   endfunction

   // ---------------- checking helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison of the registered outputs against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 irq level", {28'd0, irq}, {28'd0, m_stat & m_ien[3:0]});
         chk("R9 reset request", {31'd0, wdt_reset_req}, {31'd0, e_wdt});
         chk("R10 error flag", {31'd0, bus_err}, {31'd0, e_err});
         if (wdt_reset_req) wdt_pulses++;
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      addr = a; rd_en = 1'b1;
      #1;
      chk(tag, rdata, exp);
      chk({tag, " (model)"}, rdata, m_read(a));
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic run(int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) rd(8'(4 * a), 32'd0, "R1 reset value");
      chk("R1 irq after reset", {28'd0, irq}, 32'd0);
      chk("R1 reset request low", {31'd0, wdt_reset_req}, 32'd0);

      // R7 enable width
      wr(8'h1C, 32'hFFFF_FFFF);
      rd(8'h1C, 32'h0000_0FFF, "R7 upper enable bits zero");
      wr(8'h1C, 32'h5);

      // R11 map
      wr(8'h00, 32'd10);
      wr(8'h04, 32'd12);
      wr(8'h08, 32'd15);
      wr(8'h0C, 32'd100);
      rd(8'h04, 32'd12, "R11 match1 readback");
      rd(8'h08, 32'd15, "R11 match2 readback");
      rd(8'h10, 32'd0, "R2 hold without tick");

      // R4 / R5 matches
      run(20);
      rd(8'h10, 32'd20, "R2 counted ticks");
      rd(8'h14, 32'h5, "R4 status of enabled channels");
      chk("R4 irq of enabled channels", {28'd0, irq}, 32'h5);
      chk("R5 masked channel quiet", {31'd0, irq[1]}, 32'd0);

      // R6 clear semantics
      wr(8'h14, 32'h0);
      rd(8'h14, 32'h5, "R6 zero write no effect");
      wr(8'h14, 32'h9);
      rd(8'h14, 32'h4, "R6 write one clears");

      // R8 level follows enable
      wr(8'h1C, 32'h1);
      rd(8'h14, 32'h4, "R8 status kept when enable dropped");
      chk("R8 irq dropped", {28'd0, irq}, 32'd0);
      wr(8'h1C, 32'h5);
      chk("R8 irq back", {28'd0, irq}, 32'h4);
      wr(8'h14, 32'h4);

      // R2 wrap and R3 load
      wr(8'h10, 32'hFFFF_FFFE);
      rd(8'h10, 32'hFFFF_FFFE, "R3 load");
      run(3);
      rd(8'h10, 32'h1, "R2 wrap to zero");
      tick = 1'b1;
      wr(8'h10, 32'h55);
      tick = 1'b0;
      rd(8'h10, 32'h55, "R3 load beats tick");
      run(2);
      rd(8'h10, 32'h57, "R3 counting continues");

      // R6 hit and clear in the same cycle
      wr(8'h10, 32'd9);
      tick = 1'b1;
      wr(8'h14, 32'h1);
      tick = 1'b0;
      rd(8'h14, 32'h1, "R6 set wins over clear");
      chk("R6 irq from simultaneous hit", {28'd0, irq}, 32'h1);
      wr(8'h14, 32'h1);

      // R9 watchdog
      wr(8'h1C, 32'h0);
      wr(8'h0C, 32'h60);
      wr(8'h18, 32'h3);
      rd(8'h18, 32'h3, "R11 watchdog readback");
      wr(8'h10, 32'h5D);
      run(6);
      #1;
      chk("R9 one reset pulse", wdt_pulses, 1);
      rd(8'h18, 32'h0, "R9 watchdog disarmed");
      rd(8'h14, 32'h0, "R9 no status with enable clear");
      wr(8'h10, 32'h5D);
      run(6);
      #1;
      chk("R9 no pulse when disarmed", wdt_pulses, 1);

      // R10 unmapped access
      rd(8'h20, 32'd0, "R10 unmapped read zero");
      chk("R10 error after access", {31'd0, bus_err}, 32'd1);
      @(negedge clk);
      chk("R10 error lasts one cycle", {31'd0, bus_err}, 32'd0);
      wr(8'h24, 32'hDEAD_BEEF);
      wr(8'h02, 32'hDEAD_BEEF);
      wr(8'h1E, 32'hDEAD_BEEF);
      rd(8'h00, 32'd10, "R10 misaligned write ignored");
      rd(8'h1C, 32'd0, "R10 enable untouched");
      rd(8'h10, 32'h63, "R10 counter untouched");

      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule